// File: doc/BRIEF.md
# Watchdog Timer with Key-Protected Disable

This block is a 16-bit down-counting timer on a small register bus that can also guard a system as a watchdog. In general-purpose use, software loads a start value, picks a power-of-two clock divide and starts the count. At expiry the block raises a one-cycle interrupt pulse. It then either stops with the count at zero or reloads and runs again.

Setting the watchdog flag in the mode register turns on watchdog duty. From then on, an expiry also raises a reset request towards the system. The flag cannot be cleared by writing zero to it. The only way out is a pair of writes to the mode register whose low bytes are 0xF5 followed at once by 0xA0. If 0xF5 is followed by any other low byte, the block treats this as tampering and raises the reset request immediately. The reset request stays high until the block's own reset input is applied.

The register bus is a single-cycle write strobe with a combinational read. Reads select a register by the same address as writes.

Top module: `wdog_timer`

## Requirements
- R1: After reset, the control register (offset 0x00) reads 0, the count (offset 0x04) reads 0, the mode register (offset 0x08) reads 0, and irq and reset_req are low. The load value is 0xFFFF, so a start with no prior load write gives a count of 0xFFFF.
- R2: The control register keeps the divide select in bits [11:9], auto-reload in bit 8, run in bit 7 and free-run in bit 1. It reads these back in the same positions, and every other bit reads 0.
- R3: A write to offset 0x04 stores only the low 16 bits of write data as the load value. A control write with bit 7 set copies the load value into the count. A read of offset 0x04 returns the count zero-extended.
- R4: While running, the count decreases by one every 2^(sel+1) clock cycles, where sel is the divide select. The first decrement comes 2^(sel+1) cycles after the starting control write.
- R5: When a decrement would take the count to zero (or the count is already zero), irq is high for exactly one cycle. With auto-reload clear, the count is left at 0 and the run bit reads 0.
- R6: With auto-reload set, expiry reloads the count from the load value and counting continues, so irq pulses every load × 2^(sel+1) cycles.
- R7: A control write with bit 7 clear stops counting, and the count holds its value.
- R8: A mode-register write with bit 15 set sets the watchdog flag. A write with bit 15 clear leaves the flag unchanged. The flag reads back in bit 15 of offset 0x08.
- R9: A mode-register write with low byte 0xA0, coming directly after a mode-register write with low byte 0xF5, clears the watchdog flag. It does not raise the reset request.
- R10: A mode-register write with any low byte other than 0xA0, coming directly after a mode-register write with low byte 0xF5, raises reset_req on the next cycle. This happens whether or not the watchdog flag is set.
- R11: An expiry while the watchdog flag is set raises reset_req one cycle after the irq pulse begins. An expiry with the flag clear leaves reset_req low.
- R12: reset_req stays high until rst is applied. After reset the remembered key byte is 0x00, so a lone 0xA0 write does not clear the flag or request reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | ADDR_W (4) | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq | output | 1 | One-cycle pulse on expiry |
| reset_req | output | 1 | Sticky system reset request |

## Verification
The bench builds the block with its default parameters: a 16-bit count, a 3-bit divide select and a 4-bit offset. Small load values, together with divide selects 0 and 1, keep expiry within a few cycles. This makes it possible to check the cycle of each decrement, the irq pulse and the reset_req that follows it exactly. Divide select 7 is used to start a long count and read the loaded value back before any tick can occur. The key sequences are run both with the watchdog flag set and with it clear, and across a reset, so the remembered key byte is seen to start from zero.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    localparam int DATA_W = 32;
    localparam int SEL_W  = 3;

    localparam logic [7:0] KEY_ARM    = 8'hF5;
    localparam logic [7:0] KEY_DISARM = 8'hA0;

    localparam int SEL_LSB   = 9;
    localparam int RELOAD_B  = 8;
    localparam int RUN_B     = 7;
    localparam int FREE_B    = 1;
    localparam int WDFLAG_B  = 15;

    typedef enum logic [1:0] {
        SEL_CTRL,
        SEL_COUNT,
        SEL_MODE,
        SEL_NONE
    } reg_sel_e;

    typedef struct packed {
        logic [SEL_W-1:0] div_sel;
        logic             reload;
        logic             run;
        logic             free;
    } ctrl_fields_t;

    function automatic reg_sel_e decode_offset(input logic [7:0] off);
        case (off)
            8'h00:   return SEL_CTRL;
            8'h04:   return SEL_COUNT;
            8'h08:   return SEL_MODE;
            default: return SEL_NONE;
        endcase
    endfunction

    function automatic ctrl_fields_t unpack_ctrl(input logic [DATA_W-1:0] d);
        ctrl_fields_t c;
        c.div_sel = d[SEL_LSB +: SEL_W];
        c.reload  = d[RELOAD_B];
        c.run     = d[RUN_B];
        c.free    = d[FREE_B];
        return c;
    endfunction

    function automatic logic [DATA_W-1:0] pack_ctrl(input ctrl_fields_t c);
        logic [DATA_W-1:0] d;
        d = '0;
        d[SEL_LSB +: SEL_W] = c.div_sel;
        d[RELOAD_B]         = c.reload;
        d[RUN_B]            = c.run;
        d[FREE_B]           = c.free;
        return d;
    endfunction

endpackage

// File: rtl/wdog_prescaler.sv
module wdog_prescaler #(
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             restart,
    input  logic [SEL_W-1:0] div_sel,
    output logic             tick
);
    localparam int PRE_W = 1 << SEL_W;

    logic [PRE_W-1:0] pre_q;
    logic [PRE_W:0]   span;
    logic [PRE_W-1:0] limit;

    always_comb begin
        span  = (PRE_W+1)'(2) << div_sel;
        limit = span[PRE_W-1:0] - 1'b1;
    end

    assign tick = run && !restart && (pre_q == limit);

    always_ff @(posedge clk) begin
        if (rst || restart || !run || tick) pre_q <= '0;
        else                                pre_q <= pre_q + 1'b1;
    end

    assert_tick_spacing_R4: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);

endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ctrl_wr,
    input  logic             run_in,
    input  logic             reload,
    input  logic [CNT_W-1:0] load_val,
    input  logic             tick,
    output logic [CNT_W-1:0] count,
    output logic             running,
    output logic             expire
);
    logic at_end;
    assign at_end = running && tick && (count <= CNT_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            count   <= '0;
            running <= 1'b0;
            expire  <= 1'b0;
        end else begin
            expire <= 1'b0;
            if (ctrl_wr) begin
                running <= run_in;
                if (run_in) count <= load_val;
            end else if (at_end) begin
                expire <= 1'b1;
                if (reload) begin
                    count <= load_val;
                end else begin
                    count   <= '0;
                    running <= 1'b0;
                end
            end else if (running && tick) begin
                count <= count - 1'b1;
            end
        end
    end

    assert_pulse_width_R5: assert property (@(posedge clk) disable iff (rst)
        expire |=> !expire);
    assert_oneshot_stop_R5: assert property (@(posedge clk) disable iff (rst)
        (running && tick && count <= CNT_W'(1) && !reload && !ctrl_wr)
        |=> (!running && count == '0 && expire));
    assert_reload_R6: assert property (@(posedge clk) disable iff (rst)
        (running && tick && count <= CNT_W'(1) && reload && !ctrl_wr)
        |=> (running && count == $past(load_val)));
    assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (!ctrl_wr && !tick) |=> $stable(count));

endmodule

// File: rtl/wdog_keyguard.sv
module wdog_keyguard
    import wdog_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       mode_wr,
    input  logic [7:0] key_byte,
    input  logic       flag_set,
    input  logic       expire,
    output logic       wd_mode,
    output logic       reset_req
);
    logic [7:0] last_key;
    logic       armed;
    logic       good_key;
    logic       bad_key;

    always_comb begin
        armed    = mode_wr && (last_key == KEY_ARM);
        good_key = armed && (key_byte == KEY_DISARM);
        bad_key  = armed && (key_byte != KEY_DISARM);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            last_key  <= 8'h00;
            wd_mode   <= 1'b0;
            reset_req <= 1'b0;
        end else begin
            if (mode_wr) begin
                last_key <= key_byte;
                if (good_key)      wd_mode <= 1'b0;
                else if (flag_set) wd_mode <= 1'b1;
            end
            if (bad_key || (expire && wd_mode)) reset_req <= 1'b1;
        end
    end

    assert_mode_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !mode_wr |=> $stable(wd_mode));
    assert_key_clear_R9: assert property (@(posedge clk) disable iff (rst)
        (mode_wr && last_key == KEY_ARM && key_byte == KEY_DISARM) |=> !wd_mode);
    assert_bad_key_R10: assert property (@(posedge clk) disable iff (rst)
        (mode_wr && last_key == KEY_ARM && key_byte != KEY_DISARM) |=> reset_req);
    assert_expiry_req_R11: assert property (@(posedge clk) disable iff (rst)
        (expire && wd_mode) |=> reset_req);
    assert_sticky_req_R12: assert property (@(posedge clk) disable iff (rst)
        reset_req |=> reset_req);

endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
    import wdog_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              irq,
    output logic              reset_req
);
    reg_sel_e         sel;
    ctrl_fields_t     wr_ctrl;
    ctrl_fields_t     ctrl_q;
    logic [CNT_W-1:0] load_q;
    logic [CNT_W-1:0] count;
    logic             running;
    logic             tick;
    logic             expire;
    logic             wd_mode;
    logic             ctrl_wr;
    logic             load_wr;
    logic             mode_wr;
    logic             unused_wdata;

    assign sel          = decode_offset(8'(bus_addr));
    assign wr_ctrl      = unpack_ctrl(bus_wdata);
    assign ctrl_wr      = bus_wr && (sel == SEL_CTRL);
    assign load_wr      = bus_wr && (sel == SEL_COUNT);
    assign mode_wr      = bus_wr && (sel == SEL_MODE);
    assign unused_wdata = ^bus_wdata[31:16];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            load_q <= '1;
        end else begin
            if (ctrl_wr) ctrl_q <= wr_ctrl;
            if (load_wr) load_q <= bus_wdata[CNT_W-1:0];
        end
    end

    wdog_prescaler #(.SEL_W(SEL_W)) u_prescaler (
        .clk     (clk),
        .rst     (rst),
        .run     (running),
        .restart (ctrl_wr),
        .div_sel (ctrl_q.div_sel),
        .tick    (tick)
    );

    wdog_counter #(.CNT_W(CNT_W)) u_counter (
        .clk      (clk),
        .rst      (rst),
        .ctrl_wr  (ctrl_wr),
        .run_in   (wr_ctrl.run),
        .reload   (ctrl_q.reload),
        .load_val (load_q),
        .tick     (tick),
        .count    (count),
        .running  (running),
        .expire   (expire)
    );

    wdog_keyguard u_keyguard (
        .clk       (clk),
        .rst       (rst),
        .mode_wr   (mode_wr),
        .key_byte  (bus_wdata[7:0]),
        .flag_set  (bus_wdata[WDFLAG_B]),
        .expire    (expire),
        .wd_mode   (wd_mode),
        .reset_req (reset_req)
    );

    assign irq = expire;

    always_comb begin
        ctrl_fields_t view;
        view     = ctrl_q;
        view.run = running;
        case (sel)
            SEL_CTRL:  bus_rdata = pack_ctrl(view);
            SEL_COUNT: bus_rdata = 32'(count);
            SEL_MODE:  bus_rdata = 32'(wd_mode) << WDFLAG_B;
            default:   bus_rdata = '0;
        endcase
    end

    assert_load_copy_R3: assert property (@(posedge clk) disable iff (rst)
        (ctrl_wr && wr_ctrl.run) |=> (count == $past(load_q)));

endmodule

// File: tb/wdog_timer_bench.sv
module wdog_timer_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic        bus_wr;
    logic [3:0]  bus_addr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic        irq;
    logic        reset_req;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    localparam logic [3:0] A_CTRL = 4'h0, A_CNT = 4'h4, A_MODE = 4'h8;

    always #4 clk = ~clk;

    wdog_timer u_wdog_timer (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq), .reset_req(reset_req)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        wait_n(2);
        rst = 1'b0;
    endtask

    task automatic t_reset_state();
        logic [31:0] v;
        rd(A_CTRL, v); chk("R1 ctrl", v, 32'h0);
        rd(A_CNT, v);  chk("R1 count", v, 32'h0);
        rd(A_MODE, v); chk("R1 mode", v, 32'h0);
        chk("R1 irq", 32'(irq), 32'h0);
        chk("R1 reset_req", 32'(reset_req), 32'h0);
        wr(A_CTRL, 32'h0000_0E80);
        rd(A_CNT, v);  chk("R1 default load", v, 32'h0000_FFFF);
        wr(A_CTRL, 32'h0);
    endtask

    task automatic t_ctrl_fields();
        logic [31:0] v;
        wr(A_CTRL, 32'hFFFF_FB7F);
        rd(A_CTRL, v); chk("R2 ctrl readback", v, 32'h0000_0B02);
        wr(A_CTRL, 32'h0);
    endtask

    task automatic t_load_copy();
        logic [31:0] v;
        wr(A_CNT, 32'hABCD_1234);
        wr(A_CTRL, 32'h0000_0E80);
        rd(A_CNT, v); chk("R3 load low half", v, 32'h0000_1234);
        wr(A_CTRL, 32'h0);
    endtask

    task automatic t_divide();
        logic [31:0] v;
        wr(A_CNT, 32'd5);
        wr(A_CTRL, 32'h0000_0280);
        rd(A_CNT, v); chk("R4 start", v, 32'd5);
        wait_n(3);
        rd(A_CNT, v); chk("R4 before tick", v, 32'd5);
        wait_n(1);
        rd(A_CNT, v); chk("R4 first tick", v, 32'd4);
        wait_n(4);
        rd(A_CNT, v); chk("R4 second tick", v, 32'd3);
        wr(A_CTRL, 32'h0);
    endtask

    task automatic t_oneshot();
        logic [31:0] v;
        wr(A_CNT, 32'd3);
        wr(A_CTRL, 32'h0000_0080);
        wait_n(5);
        rd(A_CNT, v); chk("R5 count before end", v, 32'd1);
        chk("R5 irq before end", 32'(irq), 32'h0);
        wait_n(1);
        chk("R5 irq pulse", 32'(irq), 32'h1);
        rd(A_CNT, v); chk("R5 count zero", v, 32'd0);
        rd(A_CTRL, v); chk("R5 run cleared", v, 32'h0);
        chk("R11 no req outside mode", 32'(reset_req), 32'h0);
        wait_n(1);
        chk("R5 irq one cycle", 32'(irq), 32'h0);
        wait_n(4);
        rd(A_CNT, v); chk("R5 stays zero", v, 32'd0);
        chk("R11 still no req", 32'(reset_req), 32'h0);
    endtask

    task automatic t_reload();
        logic [31:0] v;
        wr(A_CNT, 32'd2);
        wr(A_CTRL, 32'h0000_0180);
        wait_n(4);
        chk("R6 first irq", 32'(irq), 32'h1);
        rd(A_CNT, v); chk("R6 reloaded", v, 32'd2);
        wait_n(1);
        chk("R6 irq low between", 32'(irq), 32'h0);
        wait_n(3);
        chk("R6 second irq", 32'(irq), 32'h1);
        rd(A_CTRL, v); chk("R6 still running", v, 32'h0000_0180);
        wr(A_CTRL, 32'h0);
    endtask

    task automatic t_stop();
        logic [31:0] v;
        wr(A_CNT, 32'd10);
        wr(A_CTRL, 32'h0000_0080);
        wait_n(4);
        rd(A_CNT, v); chk("R7 running", v, 32'd8);
        wr(A_CTRL, 32'h0);
        wait_n(10);
        rd(A_CNT, v); chk("R7 held", v, 32'd8);
    endtask

    task automatic t_mode_flag();
        logic [31:0] v;
        wr(A_MODE, 32'h0000_8000);
        rd(A_MODE, v); chk("R8 set", v, 32'h0000_8000);
        wr(A_MODE, 32'h0000_0000);
        rd(A_MODE, v); chk("R8 zero keeps flag", v, 32'h0000_8000);
        wr(A_MODE, 32'h0000_00A0);
        rd(A_MODE, v); chk("R12 lone A0 no clear", v, 32'h0000_8000);
        chk("R12 lone A0 no req", 32'(reset_req), 32'h0);
    endtask

    task automatic t_key_clear();
        logic [31:0] v;
        wr(A_MODE, 32'h0000_00F5);
        rd(A_MODE, v); chk("R9 after F5", v, 32'h0000_8000);
        wr(A_MODE, 32'h0000_00A0);
        rd(A_MODE, v); chk("R9 cleared", v, 32'h0);
        chk("R9 no req", 32'(reset_req), 32'h0);
    endtask

    task automatic t_wd_expiry();
        logic [31:0] v;
        wr(A_MODE, 32'h0000_8000);
        wr(A_CNT, 32'd2);
        wr(A_CTRL, 32'h0000_0080);
        wait_n(4);
        chk("R11 irq", 32'(irq), 32'h1);
        chk("R11 req not yet", 32'(reset_req), 32'h0);
        wait_n(1);
        chk("R11 req raised", 32'(reset_req), 32'h1);
        wait_n(20);
        chk("R12 req sticky", 32'(reset_req), 32'h1);
        do_reset();
        chk("R12 req cleared by rst", 32'(reset_req), 32'h0);
        rd(A_MODE, v); chk("R12 mode off after rst", v, 32'h0);
    endtask

    task automatic t_bad_key();
        wr(A_MODE, 32'h0000_00F5);
        chk("R10 no req after F5", 32'(reset_req), 32'h0);
        wr(A_MODE, 32'h0000_0012);
        chk("R10 bad key req", 32'(reset_req), 32'h1);
        do_reset();
    endtask

    task automatic t_key_after_reset();
        logic [31:0] v;
        wr(A_MODE, 32'h0000_80A0);
        rd(A_MODE, v); chk("R12 flag set with A0", v, 32'h0000_8000);
        chk("R12 no req", 32'(reset_req), 32'h0);
    endtask

    initial begin
        rst = 1'b1; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
        wait_n(3);
        rst = 1'b0;
        t_reset_state();
        t_ctrl_fields();
        t_load_copy();
        t_divide();
        t_oneshot();
        t_reload();
        t_stop();
        t_mode_flag();
        t_key_clear();
        t_wd_expiry();
        t_bad_key();
        t_key_after_reset();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog run did not finish actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule